// File: doc/BRIEF.md
# Oversampling Serial Receive Channel with Register Control

This block receives asynchronous serial characters on a single input line and hands them to a processor through a small register interface. A programmable divisor sets the bit rate. The line is oversampled sixteen times per bit. A falling edge starts a frame, and the start bit must still read low at mid-bit for the frame to continue. Each bit value is decided by a two-of-three vote over the samples around mid-bit. Frames carry eight data bits, or nine when the extended mode is on, and are sent least significant bit first.

Finished frames go into a two-entry buffer. Each entry keeps its own stop-bit error and ninth bit, so the status register always describes the character at the head of the buffer. A third frame that arrives while both entries are full is dropped and latches an overrun. While the overrun is latched, every later frame is also dropped. The only way to clear it is to switch the continuous-receive enable off. A receive-complete flag shows that the buffer holds data. The interrupt output is that flag gated by three enables: a channel enable, a peripheral group enable and a global enable.

The register map uses offset 0 for the divisor and offset 1 for the mode register. Offset 2 is the status/control register and offset 3 is the data register. Offset 4 holds the interrupt flag and enables. Reads are combinational. A read strobe at offset 3 also removes the head entry.

Top module: `async_rx_port`

## Requirements
- R1: One bit period lasts 16×(D+1) clock cycles when the mode register's fast bit (offset 1, bit 1) is 1, and 64×(D+1) cycles when it is 0, where D is the divisor at offset 0.
- R2: The receiver takes frames only while status bit 7 (port enable) is 1, mode bit 0 (synchronous select) is 0 and status bit 4 (continuous enable) is 1. In any other case the line is ignored and no data reaches the buffer.
- R3: In 8-bit mode a frame is a low start bit, eight data bits sent LSB first, and a stop bit. Reading offset 3 returns the oldest received byte.
- R4: When status bit 6 is 1, each frame holds nine data bits. The ninth bit of the head entry is shown in status bit 0 and stays there until the data read at offset 3 removes that entry.
- R5: The status register at offset 2, from bit 7 down to bit 0, holds: port enable, 9-bit enable, single-receive enable, continuous enable, address-detect enable, framing error, overrun, ninth bit. Bits 7 to 3 can be written; bits 2 to 0 are read-only.
- R6: A low pulse that ends before mid-bit is not taken as a start bit, and no frame is stored.
- R7: A frame whose stop bit samples as 0 is still stored. Status bit 2 reads 1 while that frame is at the head of the buffer.
- R8: The buffer holds two frames and returns them in arrival order. The receive-complete flag (offset 4, bit 0) is 1 while the buffer holds data and clears on the read that empties it.
- R9: A frame that completes while both entries are full sets overrun (status bit 1) and is discarded. Later frames are also discarded while overrun is set.
- R10: Writing continuous enable to 0 clears overrun. After that the receiver accepts frames again once the enable is set back to 1.
- R11: The interrupt output is 1 only when the flag is 1 and all three enables at offset 4 are 1: bit 1 channel, bit 2 peripheral group, bit 3 global.
- R12: After reset every register reads 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idles high |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRd | input | 1 | Read strobe; at offset 3 it removes the head entry |
| regRdData | output | 8 | Combinational read data |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach is the overrun lockout. Reaching it takes three complete frames with no data read in between. A fourth frame must then arrive and be dropped while the flag stays 1. After that, clearing continuous enable must release the receiver without disturbing the two stored bytes. The bench gets there by sending four frames back to back at the fastest rate. It then reads the status register and drains the buffer, and checks that only the first two bytes come out in order. Finally it toggles the enable and confirms that a fresh frame is received. The bit-time requirement is checked at both rate scalings by sampling the flag half a bit before and half a bit after the expected mid-stop point.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  parameter int DATA_W = 8;
  parameter int REG_W = 8;
  parameter int ADDR_W = 3;
  parameter int DIV_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_DIV  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_INT  = 3'd4;

  typedef struct packed {
    logic [DIV_W-1:0] divisor;
    logic fastMode;
    logic syncMode;
    logic portEn;
    logic nineBit;
    logic contEn;
  } rxCfg_t;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic frameEnd;
    logic stopBad;
  } rxStrobe_t;
endpackage

// File: rtl/async_rx_baud.sv
module async_rx_baud #(
  parameter int DIV_W = 8,
  parameter int SLOW_MUL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fastMode,
  output logic             ovsTick
);
  localparam int MUL_W = (SLOW_MUL > 1) ? $clog2(SLOW_MUL) : 1;
  localparam logic [MUL_W-1:0] MUL_LAST = MUL_W'(SLOW_MUL - 1);

  logic [DIV_W-1:0] divCnt;
  logic [MUL_W-1:0] mulCnt;
  logic divWrap;

  assign divWrap = (divCnt == divisor);
  assign ovsTick = divWrap && (fastMode || mulCnt == MUL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      mulCnt <= '0;
    end else if (!run) begin
      divCnt <= '0;
      mulCnt <= '0;
    end else if (divWrap) begin
      divCnt <= '0;
      if (fastMode || mulCnt == MUL_LAST) mulCnt <= '0;
      else mulCnt <= mulCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int NBITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxIn,
  input  logic      active,
  input  logic      nineBit,
  input  logic      ovsTick,
  output rxStrobe_t strb
);
  localparam int OVS_W = $clog2(OVS);
  localparam int IDX_W = $clog2(NBITS + 1);
  localparam logic [OVS_W-1:0] MID = OVS_W'(OVS / 2);
  localparam logic [OVS_W-1:0] LAST_SAMP = OVS_W'(OVS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxState_t;

  rxState_t state;
  logic rxMeta, rxSync, rxPrev;
  logic [OVS_W-1:0] sampCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [1:0] votes;
  logic [2:0] voteNow;
  logic majority, decide, lastTick, inWindow;
  logic [IDX_W-1:0] lastIdx;

  assign voteNow  = {votes, rxSync};
  assign majority = (voteNow[0] & voteNow[1]) | (voteNow[0] & voteNow[2]) | (voteNow[1] & voteNow[2]);
  assign decide   = ovsTick && sampCnt == MID + 1'b1;
  assign lastTick = ovsTick && sampCnt == LAST_SAMP;
  assign inWindow = sampCnt >= MID - 1'b1 && sampCnt <= MID + 1'b1;
  assign lastIdx  = nineBit ? IDX_W'(NBITS) : IDX_W'(NBITS - 1);

  always_comb begin
    strb = '0;
    strb.shiftEn  = (state == S_DATA) && decide;
    strb.bitVal   = majority;
    strb.frameEnd = (state == S_STOP) && decide;
    strb.stopBad  = !majority;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sampCnt <= '0;
      bitIdx  <= '0;
      votes   <= '0;
    end else if (!active) begin
      state   <= S_IDLE;
      sampCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (ovsTick) begin
        sampCnt <= sampCnt + 1'b1;
        if (inWindow) votes <= voteNow[1:0];
      end
      case (state)
        S_IDLE: if (rxPrev && !rxSync) begin
          state   <= S_START;
          sampCnt <= '0;
        end
        S_START: begin
          if (decide && majority) state <= S_IDLE;
          else if (lastTick) begin
            state  <= S_DATA;
            bitIdx <= '0;
          end
        end
        S_DATA: if (lastTick) begin
          if (bitIdx == lastIdx) state <= S_STOP;
          else bitIdx <= bitIdx + 1'b1;
        end
        S_STOP: if (decide) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRd,
  input  rxStrobe_t         strb,
  output logic [REG_W-1:0]  regRdData,
  output rxCfg_t            cfg,
  output logic              irq,
  output logic [CNT_W-1:0]  bufLevel,
  output logic              overrun
);
  localparam int ENT_W = DATA_W + 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DIV_W-1:0] divReg;
  logic fastMode, syncMode;
  logic portEn, nineBit, singleEn, contEn, addrDet;
  logic chanIe, periphIe, globalIe;
  logic [DATA_W:0] shiftReg;
  logic [ENT_W-1:0] entries [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [ENT_W-1:0] frameWord, head;
  logic push, pop, setOvr, flag;

  assign cfg = '{divisor: divReg, fastMode: fastMode, syncMode: syncMode,
                 portEn: portEn, nineBit: nineBit, contEn: contEn};

  assign frameWord = nineBit ? {strb.stopBad, shiftReg[DATA_W], shiftReg[DATA_W-1:0]}
                             : {strb.stopBad, 1'b0, shiftReg[DATA_W:1]};
  assign flag   = bufLevel != '0;
  assign pop    = regRd && regAddr == ADDR_DATA && flag;
  assign push   = strb.frameEnd && !overrun && bufLevel != FULL;
  assign setOvr = strb.frameEnd && !overrun && bufLevel == FULL;
  assign head   = flag ? entries[rdPtr] : '0;
  assign irq    = flag && chanIe && periphIe && globalIe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0; fastMode <= 1'b0; syncMode <= 1'b0;
      portEn <= 1'b0; nineBit <= 1'b0; singleEn <= 1'b0; contEn <= 1'b0; addrDet <= 1'b0;
      chanIe <= 1'b0; periphIe <= 1'b0; globalIe <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_DIV:  divReg <= regWrData[DIV_W-1:0];
        ADDR_MODE: {fastMode, syncMode} <= regWrData[1:0];
        ADDR_STAT: {portEn, nineBit, singleEn, contEn, addrDet} <= regWrData[7:3];
        ADDR_INT:  {globalIe, periphIe, chanIe} <= regWrData[3:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.bitVal, shiftReg[DATA_W:1]};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entries[g] <= '0;
      else if (push && wrPtr == PTR_W'(g)) entries[g] <= frameWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; bufLevel <= '0; overrun <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10: bufLevel <= bufLevel + 1'b1;
        2'b01: bufLevel <= bufLevel - 1'b1;
        default: ;
      endcase
      if (!contEn) overrun <= 1'b0;
      else if (setOvr) overrun <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_DIV:  regRdData[DIV_W-1:0] = divReg;
      ADDR_MODE: regRdData[1:0] = {fastMode, syncMode};
      ADDR_STAT: regRdData = {portEn, nineBit, singleEn, contEn, addrDet,
                              head[ENT_W-1], overrun, head[DATA_W]};
      ADDR_DATA: regRdData = head[DATA_W-1:0];
      ADDR_INT:  regRdData[3:0] = {globalIe, periphIe, chanIe, flag};
      default: ;
    endcase
  end
endmodule

// File: rtl/async_rx_port.sv
module async_rx_port
  import async_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int SLOW_MUL = 4,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRd,
  output logic [REG_W-1:0]  regRdData,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxCfg_t cfg;
  rxStrobe_t strb;
  logic [CNT_W-1:0] bufLevel;
  logic overrun, rxActive, ovsTick;

  assign rxActive = cfg.portEn && !cfg.syncMode && cfg.contEn;

  async_rx_baud #(.DIV_W(DIV_W), .SLOW_MUL(SLOW_MUL)) u_baud (
    .clk(clk), .rstN(rstN), .run(rxActive), .divisor(cfg.divisor),
    .fastMode(cfg.fastMode), .ovsTick(ovsTick));

  async_rx_ctrl #(.OVS(OVS), .NBITS(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .active(rxActive),
    .nineBit(cfg.nineBit), .ovsTick(ovsTick), .strb(strb));

  async_rx_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .strb(strb), .regRdData(regRdData),
    .cfg(cfg), .irq(irq), .bufLevel(bufLevel), .overrun(overrun));
endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker
  import async_rx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input rxCfg_t            cfg,
  input rxStrobe_t         strb,
  input logic [CNT_W-1:0]  bufLevel,
  input logic              overrun,
  input logic              irq,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr
);
  logic popReq;
  assign popReq = regRd && regAddr == ADDR_DATA;

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    bufLevel <= CNT_W'(DEPTH));

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun && cfg.contEn |=> overrun);

  p_ovr_no_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> bufLevel <= $past(bufLevel));

  p_cont_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.contEn |=> !overrun);

  p_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd && !overrun && bufLevel < CNT_W'(DEPTH) && !popReq
    |=> bufLevel == $past(bufLevel) + 1'b1);

  p_irq_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> bufLevel != '0);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftEn && strb.frameEnd));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(cfg.portEn && !cfg.syncMode && cfg.contEn) |-> !strb.shiftEn && !strb.frameEnd);
endmodule

bind async_rx_port async_rx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .bufLevel(bufLevel),
  .overrun(overrun), .irq(irq), .regRd(regRd), .regAddr(regAddr));

// File: tb/async_rx_port_bench.sv
module async_rx_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic regRd = 1'b0;
  logic [7:0] regRdData;
  logic irq;
  int checks = 0;
  int errors = 0;
  int bitClks = 16;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  async_rx_port u_async_rx_port (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData), .irq(irq));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, input logic strobe, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = strobe; #1; d = regRdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic holdLine(input logic b, input int n);
    @(negedge clk); rxIn = b;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic sendHead(input logic [8:0] d, input int nb);
    holdLine(1'b0, bitClks);
    for (int i = 0; i < nb; i++) holdLine(d[i], bitClks);
  endtask

  task automatic sendFrame(input logic [8:0] d, input int nb, input logic stopV);
    sendHead(d, nb);
    holdLine(stopV, bitClks);
    if (!stopV) holdLine(1'b1, bitClks);
    @(negedge clk); rxIn = 1'b1;
  endtask

  task automatic setRate(input logic [7:0] dv, input logic fast);
    wrReg(3'd1, {6'b0, fast, 1'b0});
    wrReg(3'd0, dv);
    bitClks = (fast ? 16 : 64) * (dv + 1);
  endtask

  task automatic expectByte(input logic [7:0] e, input logic ninth, input logic fe, input string req);
    logic [7:0] s, d;
    rdReg(3'd2, 1'b0, s);
    check(s[0] == ninth, {req, " ninth bit"}, s[0], ninth);
    check(s[2] == fe, {req, " framing bit"}, s[2], fe);
    rdReg(3'd3, 1'b1, d);
    check(d == e, {req, " data"}, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: reset values
    for (int a = 0; a < 5; a++) begin
      rdReg(3'(a), 1'b0, v);
      check(v == 8'h00, "R12 register reset", v, 0);
    end
    check(irq == 1'b0, "R12 irq reset", irq, 0);

    // R5: writable status bits and read-only low bits
    wrReg(3'd2, 8'hFF);
    rdReg(3'd2, 1'b0, v);
    check(v == 8'hF8, "R5 status layout", v, 8'hF8);
    wrReg(3'd2, 8'h90);

    // R3/R1: sweep over rates and byte values
    for (int r = 0; r < 4; r++) begin
      setRate(8'(r / 2), r[0] == 1'b0);
      for (int i = 0; i < 6; i++) begin
        logic [7:0] b;
        b = 8'((i * 77 + r * 29 + 5) & 255);
        sendFrame({1'b0, b}, 8, 1'b1);
        expectByte(b, 1'b0, 1'b0, "R3 sweep");
      end
    end

    // R1: flag timing around mid-stop, both scalings
    for (int r = 0; r < 2; r++) begin
      setRate(8'd1, r == 0);
      sendHead(9'h03C, 8);
      rdReg(3'd4, 1'b0, v);
      check(v[0] == 1'b0, "R1 flag before mid-stop", v[0], 0);
      holdLine(1'b1, bitClks - 2);
      rdReg(3'd4, 1'b0, v);
      check(v[0] == 1'b1, "R1 flag after stop", v[0], 1);
      expectByte(8'h3C, 1'b0, 1'b0, "R1 data");
    end

    // R4: 9-bit mode
    setRate(8'd0, 1'b1);
    wrReg(3'd2, 8'hD0);
    for (int i = 0; i < 8; i++) begin
      logic [8:0] w;
      w = 9'((i * 149 + 3) & 511);
      sendFrame(w, 9, 1'b1);
      expectByte(w[7:0], w[8], 1'b0, "R4 nine-bit");
    end
    wrReg(3'd2, 8'h90);

    // R7: framing error still stored
    sendFrame(9'h05A, 8, 1'b0);
    rdReg(3'd4, 1'b0, v);
    check(v[0] == 1'b1, "R7 bad-stop frame stored", v[0], 1);
    expectByte(8'h5A, 1'b0, 1'b1, "R7 framing");

    // R6: short low pulse rejected
    holdLine(1'b0, 4);
    holdLine(1'b1, 3 * bitClks);
    rdReg(3'd4, 1'b0, v);
    check(v[0] == 1'b0, "R6 glitch ignored", v[0], 0);

    // R8: two entries, ordered, flag clears on emptying read
    sendFrame(9'h011, 8, 1'b1);
    sendFrame(9'h0E2, 8, 1'b1);
    rdReg(3'd3, 1'b1, v);
    check(v == 8'h11, "R8 first entry", v, 8'h11);
    rdReg(3'd4, 1'b0, v);
    check(v[0] == 1'b1, "R8 flag with one left", v[0], 1);
    rdReg(3'd3, 1'b1, v);
    check(v == 8'hE2, "R8 second entry", v, 8'hE2);
    rdReg(3'd4, 1'b0, v);
    check(v[0] == 1'b0, "R8 flag clear when empty", v[0], 0);

    // R9: overrun and lockout
    sendFrame(9'h0A1, 8, 1'b1);
    sendFrame(9'h0B2, 8, 1'b1);
    sendFrame(9'h0C3, 8, 1'b1);
    rdReg(3'd2, 1'b0, v);
    check(v[1] == 1'b1, "R9 overrun set", v[1], 1);
    sendFrame(9'h0D4, 8, 1'b1);
    rdReg(3'd3, 1'b1, v);
    check(v == 8'hA1, "R9 kept first", v, 8'hA1);
    rdReg(3'd3, 1'b1, v);
    check(v == 8'hB2, "R9 kept second", v, 8'hB2);
    sendFrame(9'h0E5, 8, 1'b1);
    rdReg(3'd4, 1'b0, v);
    check(v[0] == 1'b0, "R9 lockout drops frames", v[0], 0);

    // R10: clearing continuous enable
    wrReg(3'd2, 8'h80);
    rdReg(3'd2, 1'b0, v);
    check(v[1] == 1'b0, "R10 overrun cleared", v[1], 0);
    wrReg(3'd2, 8'h90);
    sendFrame(9'h066, 8, 1'b1);
    expectByte(8'h66, 1'b0, 1'b0, "R10 receive after clear");

    // R2: disabled configurations ignore the line
    for (int k = 0; k < 3; k++) begin
      if (k == 0) wrReg(3'd1, 8'h03);
      if (k == 1) wrReg(3'd2, 8'h10);
      if (k == 2) wrReg(3'd2, 8'h80);
      sendFrame(9'h055, 8, 1'b1);
      rdReg(3'd4, 1'b0, v);
      check(v[0] == 1'b0, "R2 disabled ignores line", v[0], 0);
      wrReg(3'd1, 8'h02);
      wrReg(3'd2, 8'h90);
    end

    // R11: interrupt gating, all enable combinations
    sendFrame(9'h07E, 8, 1'b1);
    for (int m = 0; m < 8; m++) begin
      wrReg(3'd4, 8'(m << 1));
      @(negedge clk);
      check(irq == (m == 7), "R11 irq gating", irq, m == 7);
    end
    rdReg(3'd3, 1'b1, v);
    @(negedge clk);
    check(irq == 1'b0, "R11 irq drops after read", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule